// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core (Integer Subset)

This block is a 32-bit processor core that completes one instruction on every clock edge. Each cycle, the program counter addresses an instruction memory. The returned word is decoded and its operands are read from a 32-entry register file. One ALU operation is performed. The result is written back, sent to data memory, or used to steer the next program counter, all within the same cycle.

The core executes a small instruction subset:

- register-register add, subtract, AND, OR and signed set-less-than;
- word load and word store;
- branch when two registers are equal;
- absolute jump;
- jump to the address held in a register.

Instruction and data memories sit outside the core and are read combinationally. A data store is committed by the memory on the clock edge that ends the instruction.

Top module: `core_top`

## Requirements
- R1: A synchronous active-high reset sets the program counter, presented on `imem_addr`, to 0.
- R2: Outside reset, an instruction that does not redirect control moves the program counter to PC+4 on the next edge.
- R3: Opcode 000000 denotes a register-register instruction with fields rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Funct 100000 adds, 100010 subtracts, 100100 ANDs, 100101 ORs and 101010 sets 1 when rs is less than rt as signed values (0 otherwise). The result is written to rd.
- R4: Opcode 100011 loads the data word at rs plus the sign-extended 16-bit offset[15:0] into register rt.
- R5: Opcode 101011 drives `dmem_we` high with `dmem_addr` equal to rs plus the sign-extended offset and `dmem_wdata` equal to register rt. It writes no register. No other instruction raises `dmem_we`.
- R6: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2, which may point backwards. Otherwise the next PC is PC+4.
- R7: Opcode 000010 sets the next PC to bits 31:28 of PC+4, followed by instruction bits 25:0, followed by two zero bits.
- R8: Opcode 000000 with funct 001000 sets the next PC to the value of register rs and writes no register.
- R9: Register 0 always reads as zero, and writes addressed to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Data to be stored |
| dmem_we | output | 1 | Store strobe, committed at the clock edge |
| dmem_rdata | input | 32 | Data word read at `dmem_addr` |

## Verification
The assertions check control-flow properties on every cycle:

- the program counter returns to zero under reset;
- instructions that do not redirect advance the PC by exactly four;
- a jump splices its 26-bit field correctly;
- a register jump lands on the register value and writes no register;
- only a store instruction raises the store strobe.

Arithmetic results, signed comparison, negative load and store offsets, taken and untaken branches, backward branches and the immunity of register 0 cannot be seen by a property at the ports. The bench exposes them by storing register contents to memory and comparing the resulting store stream against a scoreboard. The same comparison flags any store that a correctly redirected PC must have skipped.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [5:0] FN_JR  = 6'b001000;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  // how the ALU operation is chosen: fixed add, fixed sub, or from funct
  typedef enum logic [1:0] {
    AM_ADD, AM_SUB, AM_FUNCT
  } alu_mode_e;

  typedef struct packed {
    logic      rf_we;
    logic      dst_rd;
    logic      mem_to_reg;
    logic      mem_we;
    logic      alu_imm;
    logic      branch;
    logic      jump;
    logic      jr;
    alu_mode_e alu_mode;
  } ctrl_t;
endpackage

// File: rtl/core_main_dec.sv
module core_main_dec
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  logic funct_known;

  always_comb begin
    funct_known = (funct == FN_ADD) || (funct == FN_SUB) || (funct == FN_AND) ||
                  (funct == FN_OR)  || (funct == FN_SLT);
    ctrl = '0;
    ctrl.alu_mode = AM_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.alu_mode = AM_FUNCT;
        ctrl.dst_rd   = 1'b1;
        ctrl.rf_we    = funct_known;
        ctrl.jr       = (funct == FN_JR);
      end
      OP_LOAD: begin
        ctrl.alu_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.rf_we      = 1'b1;
      end
      OP_STORE: begin
        ctrl.alu_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.alu_mode = AM_SUB;
        ctrl.branch   = 1'b1;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/core_alu_dec.sv
module core_alu_dec
  import core_pkg::*;
(
  input  alu_mode_e  mode,
  input  logic [5:0] funct,
  output alu_op_e    op
);
  always_comb begin
    op = ALU_ADD;
    case (mode)
      AM_SUB: op = ALU_SUB;
      AM_FUNCT: begin
        case (funct)
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          default: op = ALU_ADD;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int IMM_W = 16;
  localparam int JMP_W = 26;
  localparam int TOP_W = XLEN - JMP_W - 2;

  logic [XLEN-1:0] pc, pc_next, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_data;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic alu_zero;
  ctrl_t ctrl;
  alu_op_e alu_op;

  assign rs_idx = imem_rdata[25:21];
  assign rt_idx = imem_rdata[20:16];
  assign rd_idx = imem_rdata[15:11];
  assign imm_ext = {{(XLEN-IMM_W){imem_rdata[IMM_W-1]}}, imem_rdata[IMM_W-1:0]};

  core_main_dec u_main_dec (
    .opcode(imem_rdata[31:26]),
    .funct (imem_rdata[5:0]),
    .ctrl  (ctrl)
  );

  core_alu_dec u_alu_dec (
    .mode (ctrl.alu_mode),
    .funct(imem_rdata[5:0]),
    .op   (alu_op)
  );

  assign wr_idx  = ctrl.dst_rd ? rd_idx : rt_idx;
  assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;

  core_regfile #(.W(XLEN), .AW(REG_AW)) u_regfile (
    .clk    (clk),
    .we     (ctrl.rf_we),
    .waddr  (wr_idx),
    .wdata  (wb_data),
    .raddr_a(rs_idx),
    .raddr_b(rt_idx),
    .rdata_a(rs_val),
    .rdata_b(rt_val)
  );

  assign alu_b = ctrl.alu_imm ? imm_ext : rt_val;

  core_alu #(.W(XLEN)) u_alu (
    .a   (rs_val),
    .b   (alu_b),
    .op  (alu_op),
    .y   (alu_y),
    .zero(alu_zero)
  );

  assign pc_plus4   = pc + XLEN'(4);
  assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[XLEN-1 -: TOP_W], imem_rdata[JMP_W-1:0], 2'b00};

  always_comb begin
    if (ctrl.jr)                       pc_next = rs_val;
    else if (ctrl.jump)                pc_next = jmp_target;
    else if (ctrl.branch && alu_zero)  pc_next = br_target;
    else                               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we;
endmodule

// File: rtl/core_top_chk.sv
module core_top_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic [31:0] rs_val,
  input logic        rf_we,
  input logic        is_jr
);
  logic [5:0] opc;
  logic       plain;
  assign opc   = imem_rdata[31:26];
  assign plain = (opc == 6'b100011) || (opc == 6'b101011) ||
                 ((opc == 6'b000000) && (imem_rdata[5:0] != 6'b001000));

  // R1
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> imem_addr == 32'd0);

  // R2
  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    plain |=> imem_addr == $past(imem_addr) + 32'd4);

  // R5
  a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> opc == 6'b101011);

  // R7
  a_r7_jump_splice: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000010) |=>
      imem_addr == {$past(imem_addr[31:28] + ((imem_addr[27:2] == 26'h3FFFFFF) ? 4'd1 : 4'd0)),
                    $past(imem_rdata[25:0]), 2'b00});

  // R8
  a_r8_jr_target: assert property (@(posedge clk) disable iff (rst)
    is_jr |=> imem_addr == $past(rs_val));

  // R8
  a_r8_jr_no_write: assert property (@(posedge clk) disable iff (rst)
    is_jr |-> !rf_we);
endmodule

bind core_top core_top_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .imem_rdata(imem_rdata),
  .dmem_we   (dmem_we),
  .rs_val    (rs_val),
  .rf_we     (ctrl.rf_we),
  .is_jr     (ctrl.jr)
);

// File: tb/tb_core_top.sv
module tb_core_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } st_item_t;
  st_item_t exp_q[$];

  always #2 clk = ~clk;

  core_top dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] rt_op(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction
  function automatic logic [31:0] it_op(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_store(logic [31:0] a, logic [31:0] d, string tag);
    st_item_t it;
    it.a = a; it.d = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compare every store against the scoreboard
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R5/R6/R7/R8 unexpected store: actual addr %h data %h expected none",
                 dmem_addr, dmem_wdata);
      end else begin
        st_item_t it;
        it = exp_q.pop_front();
        check({it.tag, " addr"}, dmem_addr, it.a);
        check({it.tag, " data"}, dmem_wdata, it.d);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    dmem[0] = 32'd5; dmem[1] = 32'd7; dmem[2] = 32'hFFFF_FFFD;
    dmem[3] = 32'd100; dmem[4] = 32'd128;

    imem[0]  = it_op(LW, 0, 1, 0);
    imem[1]  = it_op(LW, 0, 2, 4);
    imem[2]  = it_op(LW, 0, 3, 8);
    imem[3]  = rt_op(1, 2, 4, 6'b100000);
    imem[4]  = it_op(SW, 0, 4, 64);
    imem[5]  = rt_op(1, 2, 5, 6'b100010);
    imem[6]  = it_op(SW, 0, 5, 68);
    imem[7]  = rt_op(1, 2, 6, 6'b100100);
    imem[8]  = it_op(SW, 0, 6, 72);
    imem[9]  = rt_op(1, 3, 7, 6'b100101);
    imem[10] = it_op(SW, 0, 7, 76);
    imem[11] = rt_op(3, 1, 8, 6'b101010);
    imem[12] = it_op(SW, 0, 8, 80);
    imem[13] = rt_op(1, 3, 9, 6'b101010);
    imem[14] = it_op(SW, 0, 9, 84);
    imem[15] = rt_op(1, 2, 0, 6'b100000);
    imem[16] = it_op(SW, 0, 0, 88);
    imem[17] = it_op(LW, 0, 10, 12);
    imem[18] = it_op(SW, 10, 1, -8);
    imem[19] = it_op(BEQ, 1, 2, 5);
    imem[20] = it_op(SW, 0, 2, 96);
    imem[21] = it_op(BEQ, 1, 1, 1);
    imem[22] = it_op(SW, 0, 1, 200);
    imem[23] = it_op(SW, 0, 3, 104);
    imem[24] = {6'b000010, 26'd27};
    imem[25] = it_op(SW, 0, 1, 200);
    imem[26] = it_op(SW, 0, 1, 204);
    imem[27] = it_op(SW, 0, 2, 112);
    imem[28] = it_op(LW, 0, 11, 16);
    imem[29] = rt_op(11, 0, 0, 6'b001000);
    imem[30] = it_op(SW, 0, 1, 200);
    imem[31] = it_op(SW, 0, 1, 204);
    imem[32] = it_op(SW, 0, 1, 108);
    imem[33] = it_op(BEQ, 0, 0, -1);

    expect_store(32'd64,  32'd12,         "R3 add");
    expect_store(32'd68,  32'hFFFF_FFFE,  "R3 sub");
    expect_store(32'd72,  32'd5,          "R3 and");
    expect_store(32'd76,  32'hFFFF_FFFD,  "R3 or");
    expect_store(32'd80,  32'd1,          "R3 slt signed true");
    expect_store(32'd84,  32'd0,          "R3 slt false");
    expect_store(32'd88,  32'd0,          "R9 r0 write ignored");
    expect_store(32'd92,  32'd5,          "R4 R5 negative offset");
    expect_store(32'd96,  32'd7,          "R6 not taken");
    expect_store(32'd104, 32'hFFFF_FFFD,  "R6 taken skips one");
    expect_store(32'd112, 32'd7,          "R7 jump target");
    expect_store(32'd108, 32'd5,          "R8 register jump");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", imem_addr, 32'd0);
    check("R5 no store in reset", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 first step", imem_addr, 32'd4);

    repeat (60) @(negedge clk);
    check("R6 backward branch loop", imem_addr, 32'd132);
    repeat (2) @(negedge clk);
    check("R6 loop holds", imem_addr, 32'd132);
    check("R5 all stores seen", 32'(exp_q.size()), 32'd0);
    check("R5 memory content", dmem[16], 32'd12);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule